// File: doc/BRIEF.md
# Page-Bounded Serial DMA Word Mover

This block moves characters between a 32-bit memory bus and a single serial channel, one word at a time. In transmit, it reads a word, takes the byte in bits 15:8 as the character, strobes that byte into the transmitter and moves on to the next word. The run ends when the address reaches the next page boundary. In receive, it takes characters from the receive FIFO. It writes each character into memory as a full word with the character copied into all four byte lanes. The run ends when the FIFO is empty or when the address reaches a half-page boundary, whichever comes first.

A transfer begins with a one-cycle start pulse that carries a direction and a start address. The block puts one request at a time on the memory port and holds it until the acknowledge arrives. When the run ends it raises a one-cycle done pulse with a completion count. One cycle later it raises a refresh pulse, which the surrounding controller uses to re-evaluate its status and interrupt state. A loopback input makes every transmitted character also appear as a push toward the receive FIFO.

Top module: `serdma_mover`

## Requirements
- R1: After reset the block is idle: `mem_req_o`, `tx_valid_o`, `rx_pop_o`, `lb_push_o`, `done_o` and `refresh_o` are all low.
- R2: In transmit, each word is fetched with a read (`mem_we_o` = 0). The cycle after its acknowledge, bits 15:8 of the returned word appear on `tx_byte_o` with `tx_valid_o` high for one cycle. The address then advances by 4.
- R3: A transmit run ends after the word whose incremented address has bits TX_PAGE_LG2-1:2 all zero (a 4 KB page with the default value of 12). Its done count is 1.
- R4: When `loop_en_i` is high in the cycle a character is strobed, `lb_push_o` is high in that same cycle and carries the same byte on `tx_byte_o`.
- R5: In receive, each character is popped (`rx_pop_o` for one cycle, data sampled in that cycle). It is written with `mem_we_o` = 1 as a word holding the character in all four byte lanes, and the address advances by 4.
- R6: Receive checks FIFO emptiness before every pop and never pops an empty FIFO. The run ends at the first empty check. Its done count is four times the number of characters written, and it is 0 if the FIFO is empty at start.
- R7: A receive run ends after the word whose incremented address has bits RX_PAGE_LG2-1:2 all zero (2 KB with the default value of 11). Characters left in the FIFO stay there.
- R8: At most one memory request is outstanding. While `mem_req_o` is high and unacknowledged, address, write flag and write data stay stable.
- R9: A start pulse that arrives while a run is in progress is ignored. It neither changes the current run nor triggers a second one.
- R10: `done_o` is high for exactly one cycle per run. `done_count_o` is zero outside that cycle, and `refresh_o` pulses in the cycle right after it.
- R11: The two low bits of the start address are ignored, so every access is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start pulse |
| dir_tx_i | input | 1 | 1 = transmit (memory to serial), 0 = receive |
| start_addr_i | input | ADDR_W | Start byte address |
| loop_en_i | input | 1 | Loopback enable |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data (zero on reads) |
| mem_ack_i | input | 1 | Request acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_byte_o | output | 8 | Transmit character |
| lb_push_o | output | 1 | Loopback push of `tx_byte_o` toward the receive FIFO |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_data_i | input | 8 | Receive FIFO head character |
| rx_pop_o | output | 1 | Receive FIFO pop |
| done_o | output | 1 | One-cycle completion pulse |
| done_count_o | output | RX_PAGE_LG2+1 | Completion count, valid with `done_o` |
| refresh_o | output | 1 | Status refresh pulse, cycle after `done_o` |

## Verification
The bench builds the block with ADDR_W = 16, TX_PAGE_LG2 = 6 and RX_PAGE_LG2 = 5. With these values a full transmit page is 16 words and a full receive half-page is 8 words. Complete page and half-page runs, runs that stop one word short of a boundary, and receive runs cut short by the boundary with characters still queued therefore all finish within a few hundred cycles. The same vectors also vary the acknowledge latency, the start-address low bits and the FIFO fill level, so stop conditions are exercised both alone and in combination.

// File: rtl/serdma_pkg.sv
package serdma_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int N_LANES = WORD_W / BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_WAIT = 3'd2,
        ST_STEP = 3'd3,
        ST_DONE = 3'd4
    } mover_state_e;
endpackage

// File: rtl/serdma_lane.sv
module serdma_lane
    import serdma_pkg::*;
#(
    parameter int TX_LANE = 1
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [BYTE_W-1:0] char_i,
    output logic [BYTE_W-1:0] tx_byte_o,
    output logic [WORD_W-1:0] rep_word_o
);
    // transmit character taken from a fixed byte lane
    assign tx_byte_o = word_i[TX_LANE*BYTE_W +: BYTE_W];

    // receive character copied into every byte lane
    for (genvar g = 0; g < N_LANES; g++) begin : g_rep
        assign rep_word_o[g*BYTE_W +: BYTE_W] = char_i;
    end
endmodule

// File: rtl/serdma_bound.sv
module serdma_bound #(
    parameter int ADDR_W      = 32,
    parameter int TX_PAGE_LG2 = 12,
    parameter int RX_PAGE_LG2 = 11
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              dir_tx_i,
    output logic [ADDR_W-1:0] next_addr_o,
    output logic              wrap_o
);
    localparam logic [ADDR_W-1:0] STRIDE  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] TX_MASK = ADDR_W'((64'd1 << TX_PAGE_LG2) - 64'd4);
    localparam logic [ADDR_W-1:0] RX_MASK = ADDR_W'((64'd1 << RX_PAGE_LG2) - 64'd4);

    logic [ADDR_W-1:0] mask;

    assign next_addr_o = addr_i + STRIDE;
    assign mask        = dir_tx_i ? TX_MASK : RX_MASK;
    assign wrap_o      = ((next_addr_o & mask) == '0);
endmodule

// File: rtl/serdma_mover.sv
module serdma_mover
    import serdma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int TX_PAGE_LG2 = 12,
    parameter int RX_PAGE_LG2 = 11,
    parameter int TX_LANE     = 1,
    localparam int CNT_W      = RX_PAGE_LG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_tx_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              loop_en_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_byte_o,
    output logic              lb_push_o,
    input  logic              rx_empty_i,
    input  logic [7:0]        rx_data_i,
    output logic              rx_pop_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  done_count_o,
    output logic              refresh_o
);
    localparam logic [CNT_W-1:0] CHAR_BYTES = CNT_W'(N_LANES);
    localparam logic [CNT_W-1:0] TX_OK      = CNT_W'(1);

    typedef struct packed {
        mover_state_e      st;
        logic [ADDR_W-1:0] addr;
        logic              tx;
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        logic              refresh;
    } regs_t;

    regs_t q, d;

    logic [ADDR_W-1:0] next_addr;
    logic              wrap;
    logic [WORD_W-1:0] rep_word;
    logic [BYTE_W-1:0] lane_byte;

    serdma_bound #(
        .ADDR_W     (ADDR_W),
        .TX_PAGE_LG2(TX_PAGE_LG2),
        .RX_PAGE_LG2(RX_PAGE_LG2)
    ) u_bound (
        .addr_i     (q.addr),
        .dir_tx_i   (q.tx),
        .next_addr_o(next_addr),
        .wrap_o     (wrap)
    );

    serdma_lane #(
        .TX_LANE(TX_LANE)
    ) u_lane (
        .word_i    (q.word),
        .char_i    (rx_data_i),
        .tx_byte_o (lane_byte),
        .rep_word_o(rep_word)
    );

    always_comb begin
        d          = q;
        d.refresh  = 1'b0;
        mem_req_o  = 1'b0;
        tx_valid_o = 1'b0;
        rx_pop_o   = 1'b0;
        done_o     = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.addr = {start_addr_i[ADDR_W-1:2], 2'b00};
                    d.tx   = dir_tx_i;
                    d.cnt  = '0;
                    d.word = '0;
                    d.st   = ST_REQ;
                end
            end
            ST_REQ: begin
                if (!q.tx && rx_empty_i) begin
                    d.st = ST_DONE;
                end else begin
                    if (!q.tx) begin
                        rx_pop_o = 1'b1;
                        d.word   = rep_word;
                    end
                    d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                mem_req_o = 1'b1;
                if (mem_ack_i) begin
                    if (q.tx) begin
                        d.word = mem_rdata_i;
                    end
                    d.st = ST_STEP;
                end
            end
            ST_STEP: begin
                d.addr = next_addr;
                if (q.tx) begin
                    tx_valid_o = 1'b1;
                end else begin
                    d.cnt = q.cnt + CHAR_BYTES;
                end
                d.st = wrap ? ST_DONE : ST_REQ;
            end
            ST_DONE: begin
                done_o    = 1'b1;
                d.refresh = 1'b1;
                d.st      = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_we_o     = !q.tx;
    assign mem_addr_o   = q.addr;
    assign mem_wdata_o  = q.tx ? '0 : q.word;
    assign tx_byte_o    = tx_valid_o ? lane_byte : '0;
    assign lb_push_o    = tx_valid_o && loop_en_i;
    assign done_count_o = done_o ? (q.tx ? TX_OK : q.cnt) : '0;
    assign refresh_o    = q.refresh;
endmodule

// File: rtl/serdma_mover_chk.sv
module serdma_mover_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loop_en_i,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [31:0]       mem_wdata_o,
    input logic              mem_ack_i,
    input logic              tx_valid_o,
    input logic              lb_push_o,
    input logic              rx_empty_i,
    input logic              rx_pop_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  done_count_o,
    input logic              refresh_o
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_req_o && !tx_valid_o && !rx_pop_o && !done_o);

    assert_tx_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> $past(mem_req_o && mem_ack_i && !mem_we_o));

    assert_lb_with_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lb_push_o |-> tx_valid_o && loop_en_i);

    assert_no_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop_o |-> !rx_empty_i);

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && refresh_o);

    assert_count_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> done_count_o == '0);

    assert_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_addr_o[1:0] == 2'b00);
endmodule

bind serdma_mover serdma_mover_chk #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .loop_en_i   (loop_en_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .tx_valid_o  (tx_valid_o),
    .lb_push_o   (lb_push_o),
    .rx_empty_i  (rx_empty_i),
    .rx_pop_o    (rx_pop_o),
    .done_o      (done_o),
    .done_count_o(done_count_o),
    .refresh_o   (refresh_o)
);

// File: tb/test_serdma_mover.sv
module test_serdma_mover;
    localparam int AW    = 16;
    localparam int TXL   = 6;
    localparam int RXL   = 5;
    localparam int CW    = RXL + 1;
    localparam int NVEC  = 8;
    localparam logic [AW-1:0] TXM = AW'((1 << TXL) - 4);
    localparam logic [AW-1:0] RXM = AW'((1 << RXL) - 4);

    // vector: [31] tx, [27:24] ack latency, [23:16] fifo fill, [15:0] start address
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b1, 3'd0, 4'd0, 8'd0,  16'h0100},
        {1'b1, 3'd0, 4'd0, 8'd0,  16'h0138},
        {1'b1, 3'd0, 4'd3, 8'd0,  16'h017C},
        {1'b1, 3'd0, 4'd1, 8'd0,  16'h0207},
        {1'b0, 3'd0, 4'd0, 8'd5,  16'h0300},
        {1'b0, 3'd0, 4'd2, 8'd6,  16'h0310},
        {1'b0, 3'd0, 4'd0, 8'd0,  16'h0340},
        {1'b0, 3'd0, 4'd1, 8'd12, 16'h0302}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, dir_tx_i = 1'b0, loop_en_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic mem_req_o, mem_we_o, mem_ack_i, tx_valid_o, lb_push_o, rx_empty_i, rx_pop_o;
    logic done_o, refresh_o;
    logic [AW-1:0] mem_addr_o;
    logic [31:0] mem_wdata_o, mem_rdata_i;
    logic [7:0] tx_byte_o, rx_data_i;
    logic [CW-1:0] done_count_o;

    always #4 clk = ~clk;

    serdma_mover #(.ADDR_W(AW), .TX_PAGE_LG2(TXL), .RX_PAGE_LG2(RXL)) i_serdma_mover (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_tx_i(dir_tx_i),
        .start_addr_i(start_addr_i), .loop_en_i(loop_en_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o), .lb_push_o(lb_push_o),
        .rx_empty_i(rx_empty_i), .rx_data_i(rx_data_i), .rx_pop_o(rx_pop_o),
        .done_o(done_o), .done_count_o(done_count_o), .refresh_o(refresh_o)
    );

    int nvec = 0, nerr = 0;
    int lat = 0, wcnt = 0;
    logic [7:0] fifo [64];
    int f_wr = 0, f_rd = 0;
    logic pend_pop = 1'b0;
    logic [AW-1:0] acc_addr [64];
    logic acc_we [64];
    logic [31:0] acc_data [64];
    int n_acc = 0;
    logic [7:0] tx_log [64];
    int n_tx = 0, n_lb = 0, lb_bad = 0;
    int done_seen = 0, refresh_seen = 0, refresh_bad = 0;
    logic [CW-1:0] last_count = '0;
    logic prev_done = 1'b0;
    int cycles = 0;

    function automatic logic [7:0] lane1(input logic [AW-1:0] a);
        return a[9:2] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
        return {8'hC3, ~a[7:0], lane1(a), a[7:0]};
    endfunction

    assign rx_empty_i = (f_wr == f_rd);
    assign rx_data_i  = fifo[f_rd % 64];

    // memory responder, FIFO model and output monitor, all on the falling edge
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            mem_ack_i <= 1'b0;
            wcnt = 0;
        end else begin
            if (pend_pop) begin
                f_rd = f_rd + 1;
                pend_pop = 1'b0;
            end
            if (rx_pop_o) pend_pop = 1'b1;
            if (mem_ack_i) begin
                mem_ack_i <= 1'b0;
            end else if (mem_req_o) begin
                if (wcnt >= lat) begin
                    mem_ack_i <= 1'b1;
                    mem_rdata_i <= mem_word(mem_addr_o);
                    if (n_acc < 64) begin
                        acc_addr[n_acc] = mem_addr_o;
                        acc_we[n_acc]   = mem_we_o;
                        acc_data[n_acc] = mem_wdata_o;
                    end
                    n_acc = n_acc + 1;
                    wcnt = 0;
                end else begin
                    wcnt = wcnt + 1;
                end
            end
            if (tx_valid_o) begin
                if (n_tx < 64) tx_log[n_tx] = tx_byte_o;
                n_tx = n_tx + 1;
            end
            if (lb_push_o) begin
                n_lb = n_lb + 1;
                fifo[f_wr % 64] = tx_byte_o;
                f_wr = f_wr + 1;
            end
            if (lb_push_o != (tx_valid_o && loop_en_i)) lb_bad = lb_bad + 1;
            if (done_o) begin
                done_seen = done_seen + 1;
                last_count = done_count_o;
            end
            if (refresh_o) begin
                refresh_seen = refresh_seen + 1;
                if (!prev_done) refresh_bad = refresh_bad + 1;
            end
            prev_done = done_o;
        end
    end

    initial mem_rdata_i = '0;
    initial mem_ack_i = 1'b0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        nvec = nvec + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_acc = 0; n_tx = 0; n_lb = 0; lb_bad = 0;
        done_seen = 0; refresh_seen = 0; refresh_bad = 0;
    endtask

    task automatic pulse_start(input logic tx, input logic [AW-1:0] a);
        @(negedge clk);
        start_i = 1'b1; dir_tx_i = tx; start_addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (done_seen < target && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        check(done_seen == target, "R10 done pulses", done_seen, target);
    endtask

    // expected number of words and run checks for one transfer
    task automatic run_one(input logic tx, input logic [AW-1:0] a, input int fill,
                           input int l, input logic [7:0] base);
        logic [AW-1:0] wa;
        int exp_n, bad;
        clear_logs();
        f_wr = 0; f_rd = 0;
        for (int i = 0; i < fill; i++) begin
            fifo[i] = base + 8'(i);
            f_wr = f_wr + 1;
        end
        lat = l;
        pulse_start(tx, a);
        wait_done(1);
        wa = {a[AW-1:2], 2'b00};
        exp_n = 0;
        if (tx || fill > 0) begin
            do begin
                wa = wa + AW'(4);
                exp_n++;
            end while (((wa & (tx ? TXM : RXM)) != '0) && (tx || exp_n < fill));
        end
        bad = 0;
        wa = {a[AW-1:2], 2'b00};
        for (int i = 0; i < exp_n && i < 64; i++) begin
            if (acc_addr[i] != wa + AW'(4*i)) bad++;
            if (acc_we[i] != !tx) bad++;
            if (tx) begin
                if (tx_log[i] != lane1(wa + AW'(4*i))) bad++;
            end else begin
                if (acc_data[i] != {4{base + 8'(i)}}) bad++;
            end
        end
        if (tx) begin
            check(n_acc == exp_n, "R3 word count", n_acc, exp_n);
            check(n_tx == exp_n, "R2 bytes sent", n_tx, exp_n);
            check(bad == 0, "R2 R11 address/lane mismatches", bad, 0);
            check(last_count == CW'(1), "R3 done count", int'(last_count), 1);
        end else begin
            check(n_acc == exp_n, "R6 R7 word count", n_acc, exp_n);
            check(bad == 0, "R5 address/replica mismatches", bad, 0);
            check(last_count == CW'(4*exp_n), "R6 done count", int'(last_count), 4*exp_n);
            check(f_wr - f_rd == fill - exp_n, "R7 chars left in FIFO", f_wr - f_rd, fill - exp_n);
        end
        check(refresh_seen == 1 && refresh_bad == 0, "R10 refresh after done", refresh_seen, 1);
    endtask

    initial begin : watchdog
        wait (cycles >= 150000);
        nerr = nerr + 1;
        nvec = nvec + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R1: idle after reset
        check(!mem_req_o && !tx_valid_o && !rx_pop_o && !done_o && !refresh_o && !lb_push_o,
              "R1 outputs idle in reset", int'(mem_req_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!mem_req_o && !done_o && !tx_valid_o && !rx_pop_o,
              "R1 outputs idle after reset", int'(mem_req_o), 0);

        for (int k = 0; k < NVEC; k++) begin
            run_one(VEC[k][31], VEC[k][15:0], int'(VEC[k][23:16]), int'(VEC[k][27:24]),
                    8'h20 + 8'(16*k));
        end

        // R9: start pulse during a transmit run is ignored
        clear_logs();
        lat = 2; f_wr = 0; f_rd = 0;
        for (int i = 0; i < 4; i++) begin
            fifo[i] = 8'h77; f_wr = f_wr + 1;
        end
        pulse_start(1'b1, 16'h0100);
        repeat (6) @(negedge clk);
        pulse_start(1'b0, 16'h0380);
        wait_done(1);
        check(n_acc == 16, "R9 words of first run only", n_acc, 16);
        check(f_wr - f_rd == 4, "R9 FIFO untouched", f_wr - f_rd, 4);
        repeat (20) @(negedge clk);
        check(done_seen == 1, "R9 no second run", done_seen, 1);

        // R4: loopback pushes the transmitted byte, then receive writes it back
        clear_logs();
        lat = 0; f_wr = 0; f_rd = 0;
        loop_en_i = 1'b1;
        pulse_start(1'b1, 16'h013C);
        wait_done(1);
        loop_en_i = 1'b0;
        check(n_lb == 1 && lb_bad == 0, "R4 loopback push count", n_lb, 1);
        check(f_wr == 1 && fifo[0] == lane1(16'h013C), "R4 loopback byte",
              int'(fifo[0]), int'(lane1(16'h013C)));
        clear_logs();
        pulse_start(1'b0, 16'h0400);
        wait_done(1);
        check(n_acc == 1 && acc_we[0] && acc_data[0] == {4{lane1(16'h013C)}},
              "R4 R5 looped char replicated", int'(acc_data[0][7:0]), int'(lane1(16'h013C)));
        check(last_count == CW'(4), "R6 count for one char", int'(last_count), 4);

        // R4: loopback off gives no push
        clear_logs();
        f_wr = 0; f_rd = 0;
        pulse_start(1'b1, 16'h013C);
        wait_done(1);
        check(n_lb == 0 && f_wr == 0, "R4 no push without loopback", n_lb, 0);

        // R1: reset in mid-run returns to idle
        lat = 5;
        pulse_start(1'b1, 16'h0100);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!mem_req_o && !tx_valid_o && !done_o, "R1 idle after mid-run reset", int'(mem_req_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!mem_req_o && !done_o, "R1 stays idle without start", int'(mem_req_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule